// File: doc/BRIEF.md
# I2C Reserved-Address Command Decoder

This block sits beside the target-side logic of an I2C device and watches the first byte after every START or repeated START. It handles two reserved first bytes.

The first is the general call address with a write direction. When it is followed by a recognised command byte, the block re-samples the static address-select pins into a held register. For one of the two commands it also emits a one-cycle soft-reset request that the device's register file uses to return to its power-up values.

The second is the high-speed controller code. The block never acknowledges this code, but it raises a mode flag that selects the high-speed filter setting. The flag stays high across repeated STARTs and is cleared only by a STOP.

SCL and SDA arrive already synchronised to the block clock. The only bus output is an open-drain pull-down request used for the acknowledge bits.

Top module: `i2c_rsv_decoder`

## Requirements
- R1: After synchronous reset, sda_pull_o, soft_rst_o and hs_mode_o are 0, and addr_latched_o holds the addr_pins_i value present during reset.
- R2: A first byte of 0x00 (seven zero address bits followed by a write bit of 0) is acknowledged. sda_pull_o goes high after the SCL fall that ends the eighth bit and is released after the SCL fall that ends the ninth bit.
- R3: A first byte of 0x01 (general call with the read bit at 1) is not acknowledged and causes no latch, pulse or mode change.
- R4: After an acknowledged general call, a command byte of 0x04 is acknowledged. When its acknowledge slot ends, addr_latched_o takes the current addr_pins_i and no soft-reset pulse is issued.
- R5: After an acknowledged general call, a command byte of 0x06 is acknowledged. When its acknowledge slot ends, addr_latched_o takes addr_pins_i and soft_rst_o is high for exactly one clock.
- R6: Any other command byte after a general call is not acknowledged. addr_latched_o keeps its value even if the pins have changed, and no pulse is issued.
- R7: A first byte whose upper five bits are 00001 (0x08 to 0x0F) is not acknowledged. hs_mode_o rises after its eighth bit is sampled.
- R8: hs_mode_o stays high across repeated STARTs and the bytes that follow them, and falls after a STOP.
- R9: Only the first byte after a START or repeated START is decoded. Values of 0x00 or 0x08 that appear in later bytes of a transfer are ignored.
- R10: A soft-reset pulse issued while in high-speed mode leaves hs_mode_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (bus wire) |
| addr_pins_i | input | ADDR_PINS_W | Static address-select pin levels |
| sda_pull_o | output | 1 | Request to pull SDA low (acknowledge) |
| addr_latched_o | output | ADDR_PINS_W | Held address-pin value |
| soft_rst_o | output | 1 | One-cycle register reset request |
| hs_mode_o | output | 1 | High-speed filter setting selected |

## Verification
Two functions can act in the same cycle. The soft-reset pulse from a 0x06 command can arrive while the high-speed flag is already set. The bench provokes this by sending the high-speed code, then a repeated START with a general call and 0x06, all before any STOP. It then checks every clock against a behavioural model that both the pulse fires exactly once and the mode flag remains high through it and after it. The release of the acknowledge pull-down and the address re-latch also share one clock edge; per-cycle comparison judges that edge.

// File: rtl/i2c_rsv_pkg.sv
package i2c_rsv_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] GC_WRITE_BYTE  = 8'h00;
    localparam logic [BYTE_W-1:0] CMD_PIN_LATCH  = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_LATCH_RST  = 8'h06;
    localparam logic [4:0]        HS_CODE_PREFIX = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_SKIP
    } dec_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    typedef struct packed {
        logic latch;
        logic reset;
    } gc_action_t;

    function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:BYTE_W-5] == HS_CODE_PREFIX;
    endfunction

    function automatic gc_action_t decode_cmd(input logic [BYTE_W-1:0] b);
        gc_action_t a;
        a.latch = (b == CMD_PIN_LATCH) || (b == CMD_LATCH_RST);
        a.reset = (b == CMD_LATCH_RST);
        return a;
    endfunction

endpackage

// File: rtl/i2c_rsv_events.sv
module i2c_rsv_events
    import i2c_rsv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.start    = scl_q && scl_i && sda_q && !sda_i;
        ev_o.stop     = scl_q && scl_i && !sda_q && sda_i;
        ev_o.scl_rise = !scl_q && scl_i;
        ev_o.scl_fall = scl_q && !scl_i;
    end
endmodule

// File: rtl/i2c_rsv_shifter.sv
module i2c_rsv_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         sample_i,
    input  logic         bit_i,
    output logic         done_o,
    output logic [W-1:0] byte_o
);
    localparam int CNT_W = $clog2(W) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;

    assign done_o = sample_i && (cnt_q == LAST);
    assign byte_o = {sh_q[W-2:0], bit_i};

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (sample_i) begin
            sh_q  <= byte_o;
            cnt_q <= done_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_rsv_decoder.sv
module i2c_rsv_decoder
    import i2c_rsv_pkg::*;
#(
    parameter int ADDR_PINS_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [ADDR_PINS_W-1:0] addr_pins_i,
    output logic                   sda_pull_o,
    output logic [ADDR_PINS_W-1:0] addr_latched_o,
    output logic                   soft_rst_o,
    output logic                   hs_mode_o
);
    bus_ev_t           ev;
    dec_state_t        st;
    gc_action_t        act_q, act_new;
    logic              byte_done, sample;
    logic [BYTE_W-1:0] rx_byte;

    i2c_rsv_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    assign sample = ev.scl_rise && (st == ST_ADDR || st == ST_CMD);

    i2c_rsv_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (ev.start),
        .sample_i (sample),
        .bit_i    (sda_i),
        .done_o   (byte_done),
        .byte_o   (rx_byte)
    );

    assign act_new = decode_cmd(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= ST_IDLE;
            sda_pull_o     <= 1'b0;
            hs_mode_o      <= 1'b0;
            soft_rst_o     <= 1'b0;
            addr_latched_o <= addr_pins_i;
            act_q          <= '0;
        end else begin
            soft_rst_o <= 1'b0;
            if (ev.start) begin
                st         <= ST_ADDR;
                sda_pull_o <= 1'b0;
            end else if (ev.stop) begin
                st         <= ST_IDLE;
                sda_pull_o <= 1'b0;
                hs_mode_o  <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (byte_done) begin
                        if (rx_byte == GC_WRITE_BYTE) begin
                            st <= ST_ADDR_ACK;
                        end else begin
                            st <= ST_SKIP;
                            if (is_hs_code(rx_byte)) hs_mode_o <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: if (ev.scl_fall) begin
                        if (!sda_pull_o) begin
                            sda_pull_o <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                            st         <= ST_CMD;
                        end
                    end
                    ST_CMD: if (byte_done) begin
                        act_q <= act_new;
                        st    <= act_new.latch ? ST_CMD_ACK : ST_SKIP;
                    end
                    ST_CMD_ACK: if (ev.scl_fall) begin
                        if (!sda_pull_o) begin
                            sda_pull_o <= 1'b1;
                        end else begin
                            sda_pull_o <= 1'b0;
                            st         <= ST_SKIP;
                            if (act_q.latch) addr_latched_o <= addr_pins_i;
                            soft_rst_o <= act_q.reset;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5
    soft_rst_single_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |=> !soft_rst_o);

    // R5
    soft_rst_latch_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst_o |-> addr_latched_o == $past(addr_pins_i));

    // R8
    stop_clears_hs_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !hs_mode_o);

    // R7
    hs_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode_o) |-> !sda_pull_o);

    // R2
    pull_stable_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

endmodule

// File: tb/i2c_rsv_decoder_tb.sv
module i2c_rsv_decoder_tb_top;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b1;
    logic          sda_drv = 1'b1;
    logic [PW-1:0] pins = 3'd3;
    logic          sda_pull, soft_rst, hs_mode;
    logic [PW-1:0] addr_lat;
    wire           sda_bus = sda_drv & ~sda_pull;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    int    pulse_cnt = 0, pulse_run = 0, pulse_max = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_rsv_decoder #(.ADDR_PINS_W(PW)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .addr_pins_i(pins), .sda_pull_o(sda_pull),
        .addr_latched_o(addr_lat), .soft_rst_o(soft_rst), .hs_mode_o(hs_mode)
    );

    // behavioural reference: 0 idle,1 first byte,2 ack gc,3 command,4 ack cmd,5 ignore
    int         m_st, m_cmd;
    bit         m_pull, m_hs, m_srst, m_pscl, m_psda;
    bit [PW-1:0] m_addr;
    bit         m_bits[$];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pull = 0; m_hs = 0; m_srst = 0; m_addr = pins;
            m_pscl = 1; m_psda = 1; m_bits.delete();
        end else begin
            m_srst = 0;
            if (m_pscl && scl && m_psda && !sda_bus) begin
                m_st = 1; m_pull = 0; m_bits.delete();
            end else if (m_pscl && scl && !m_psda && sda_bus) begin
                m_st = 0; m_pull = 0; m_hs = 0;
            end else if (!m_pscl && scl && (m_st == 1 || m_st == 3)) begin
                int v;
                m_bits.push_back(sda_bus);
                if (m_bits.size() == 8) begin
                    v = 0;
                    foreach (m_bits[i]) v = v * 2 + int'(m_bits[i]);
                    m_bits.delete();
                    if (m_st == 1) begin
                        if (v == 0) m_st = 2;
                        else begin m_st = 5; if (v >= 8 && v <= 15) m_hs = 1; end
                    end else begin
                        m_cmd = v;
                        m_st = (v == 4 || v == 6) ? 4 : 5;
                    end
                end
            end else if (m_pscl && !scl && (m_st == 2 || m_st == 4)) begin
                if (!m_pull) m_pull = 1;
                else begin
                    m_pull = 0;
                    if (m_st == 4) begin
                        m_addr = pins;
                        m_srst = (m_cmd == 6);
                    end
                    m_st = (m_st == 2) ? 3 : 5;
                end
            end
            m_pscl = scl; m_psda = sda_bus;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(sda_pull == m_pull, cur_req, sda_pull, m_pull, "sda_pull_o vs model");
            check(soft_rst == m_srst, cur_req, soft_rst, m_srst, "soft_rst_o vs model");
            check(hs_mode == m_hs, cur_req, hs_mode, m_hs, "hs_mode_o vs model");
            check(addr_lat == m_addr, cur_req, addr_lat, m_addr, "addr_latched_o vs model");
            if (soft_rst) begin pulse_run++; pulse_cnt += (pulse_run == 1); end
            else pulse_run = 0;
            if (pulse_run > pulse_max) pulse_max = pulse_run;
        end
    end

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic bus_start(); sda_drv = 1; w(2); scl = 1; w(3); sda_drv = 0; w(3); scl = 0; w(2); endtask
    task automatic bus_stop();  sda_drv = 0; w(2); scl = 1; w(3); sda_drv = 1; w(4); endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; w(2); scl = 1; w(4); scl = 0; w(2);
        end
        sda_drv = 1; w(3); scl = 1; w(2);
        acked = sda_pull;
        w(2); scl = 0; w(3);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit a1, a2;
        int p0;
        w(4); rst = 0; w(2);

        // R1 reset state
        check(addr_lat == 3'd3, "R1", addr_lat, 3, "latched pins after reset");
        check(!sda_pull && !soft_rst && !hs_mode, "R1", {sda_pull, soft_rst, hs_mode}, 0, "outputs after reset");

        // R2 R4 general call + latch-only command
        cur_req = "R4"; pins = 3'd5; p0 = pulse_cnt;
        bus_start(); send_byte(8'h00, a1); send_byte(8'h04, a2); bus_stop();
        check(a1, "R2", a1, 1, "general call address ack");
        check(a2, "R4", a2, 1, "command 0x04 ack");
        check(addr_lat == 3'd5, "R4", addr_lat, 5, "latched pins after 0x04");
        check(pulse_cnt == p0, "R4", pulse_cnt - p0, 0, "no reset pulse on 0x04");

        // R5 latch + reset
        cur_req = "R5"; pins = 3'd2; p0 = pulse_cnt;
        bus_start(); send_byte(8'h00, a1); send_byte(8'h06, a2); bus_stop();
        check(a2, "R5", a2, 1, "command 0x06 ack");
        check(addr_lat == 3'd2, "R5", addr_lat, 2, "latched pins after 0x06");
        check(pulse_cnt == p0 + 1, "R5", pulse_cnt - p0, 1, "reset pulse count");
        check(pulse_max == 1, "R5", pulse_max, 1, "reset pulse width");

        // R6 unknown command
        cur_req = "R6"; pins = 3'd6; p0 = pulse_cnt;
        bus_start(); send_byte(8'h00, a1); send_byte(8'h07, a2); bus_stop();
        check(!a2, "R6", a2, 0, "unknown command not acked");
        check(addr_lat == 3'd2, "R6", addr_lat, 2, "latch unchanged");
        check(pulse_cnt == p0, "R6", pulse_cnt - p0, 0, "no pulse");

        // R3 general call read
        cur_req = "R3"; p0 = pulse_cnt;
        bus_start(); send_byte(8'h01, a1); send_byte(8'h06, a2); bus_stop();
        check(!a1 && !a2, "R3", {a1, a2}, 0, "read general call not acked");
        check(addr_lat == 3'd2 && pulse_cnt == p0, "R3", addr_lat, 2, "no action on read general call");

        // R7 R8 R10 high-speed code, repeated starts, reset pulse in hs mode
        cur_req = "R7";
        bus_start(); send_byte(8'h0B, a1);
        check(!a1, "R7", a1, 0, "hs code not acked");
        check(hs_mode, "R7", hs_mode, 1, "hs mode entered");
        cur_req = "R8";
        bus_start(); send_byte(8'h90, a1); send_byte(8'h00, a2);
        check(hs_mode && !a1, "R8", hs_mode, 1, "hs persists over repeated start");
        cur_req = "R10"; pins = 3'd7; p0 = pulse_cnt;
        bus_start(); send_byte(8'h00, a1); send_byte(8'h06, a2);
        check(a1 && a2 && pulse_cnt == p0 + 1, "R10", pulse_cnt - p0, 1, "pulse during hs mode");
        check(hs_mode, "R10", hs_mode, 1, "hs kept through pulse");
        check(addr_lat == 3'd7, "R10", addr_lat, 7, "latched in hs mode");
        cur_req = "R8";
        bus_stop();
        check(!hs_mode, "R8", hs_mode, 0, "stop clears hs mode");

        // R9 reserved values in later bytes
        cur_req = "R9"; pins = 3'd1; p0 = pulse_cnt;
        bus_start(); send_byte(8'h90, a1); send_byte(8'h00, a2); send_byte(8'h0C, a1);
        check(!hs_mode, "R9", hs_mode, 0, "late hs code ignored");
        send_byte(8'h06, a2); bus_stop();
        check(!a2 && addr_lat == 3'd7 && pulse_cnt == p0, "R9", addr_lat, 7, "late general call ignored");

        w(4);
        finish_run();
    end
endmodule